// File: doc/BRIEF.md
# Bus Request Acknowledge Controller

This block decides when an 8-bit processor bus interface gives its address bus, data bus and control strobes to an outside bus master. A cycle sequencer outside the block supplies a T-state strobe and a flag that marks the last T state of a machine cycle. The controller watches an active-low request from the outside master. It takes that request only at the end of a machine cycle. One T state later it drives an active-low acknowledge and turns off every bus driver. It also holds a stall line that freezes the sequencer's counters.

While the bus is granted, the controller looks at the request on every T state. When the master lets the request go, the acknowledge stays low for one more T state. The drivers are then turned back on, the stall drops, and a one-clock resume pulse tells the sequencer to carry on from the machine cycle at which it stopped. The controller itself executes no instructions and moves no data.

Top module: `bus_grant_ctrl`

## Requirements
- R1: `breq_n` is acted on only at a rising clock edge where both `t_tick` and `last_t` are 1; a low `breq_n` at such an edge counts as a request.
- R2: After a request is taken, `back_n` stays 1 until the next edge with `t_tick` = 1, and goes to 0 at that edge.
- R3: Every bit of `addr_oe`, `data_oe` and `strb_oe` is 0 while `back_n` is 0 and 1 while `back_n` is 1. In `strb_oe`, bit 0 is memory request, bit 1 read, bit 2 write, bit 3 I/O request and bit 4 refresh.
- R4: While the bus is granted, `breq_n` is sampled at every edge with `t_tick` = 1; a 1 at such an edge starts the release.
- R5: `back_n` returns to 1 at the first `t_tick` edge after the edge that saw the release. `resume` is 1 for exactly one clock after that same edge.
- R6: `stall` is 1 from the edge that takes the request until the edge at which `back_n` returns to 1, and it is 0 at all other times.
- R7: A sequencer that advances only on `t_tick` edges with `stall` = 0 keeps the same machine-cycle position through the whole grant, and continues from that position after release.
- R8: A low `breq_n` at an edge where `t_tick` or `last_t` is 0 has no effect: `back_n` stays 1 and `stall` stays 0.
- R9: After reset, `back_n` = 1, all output enables are 1, and `stall` = 0 and `resume` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| t_tick | input | 1 | T-state strobe from the sequencer; one clock per T-state boundary |
| last_t | input | 1 | The current T state is the last of its machine cycle |
| breq_n | input | 1 | Active-low bus request from the outside master |
| back_n | output | 1 | Active-low bus acknowledge |
| addr_oe | output | 16 | Per-bit address driver enable, 1 = driving |
| data_oe | output | 8 | Per-bit data driver enable, 1 = driving |
| strb_oe | output | 5 | Strobe driver enables (memory request, read, write, I/O request, refresh) |
| stall | output | 1 | Holds the sequencer's T-state and machine-cycle counters |
| resume | output | 1 | One-clock pulse when the bus is handed back |

## Verification
Every output is registered. A change of `back_n`, `stall` and the enables follows one clock after the `t_tick` edge that causes it. `resume` is high in the clock that follows the releasing edge. The bench drives inputs at the falling edge. It advances its own reference model at the rising edge and compares all outputs at the next falling edge, so each result is checked in the cycle it is due. The bench's sequencer model shows that the machine-cycle count does not change while `stall` is high, and it checks that the request is ignored whenever it appears away from the last T state.

// File: rtl/bgc_pkg.sv
package bgc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PEND  = 2'd1,
    ST_GRANT = 2'd2,
    ST_REL   = 2'd3
  } bgc_state_e;
endpackage

// File: rtl/bgc_rst_sync.sv
module bgc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bgc_sample.sv
module bgc_sample (
  input  logic t_tick,
  input  logic last_t,
  input  logic breq_n,
  output logic take_req,
  output logic seen_free
);
  always_comb begin
    take_req  = t_tick & last_t & ~breq_n;
    seen_free = t_tick & breq_n;
  end
endmodule

// File: rtl/bgc_fsm.sv
module bgc_fsm
  import bgc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic t_tick,
  input  logic take_req,
  input  logic seen_free,
  output logic float_req,
  output logic back_n,
  output logic stall,
  output logic resume
);
  bgc_state_e st_q, st_nxt;
  logic       st_en;
  logic       back_n_nxt, stall_nxt, resume_nxt;

  always_comb begin
    st_nxt = st_q;
    unique case (st_q)
      ST_IDLE:  if (take_req)  st_nxt = ST_PEND;
      ST_PEND:  if (t_tick)    st_nxt = ST_GRANT;
      ST_GRANT: if (seen_free) st_nxt = ST_REL;
      ST_REL:   if (t_tick)    st_nxt = ST_IDLE;
      default:                 st_nxt = ST_IDLE;
    endcase
    st_en      = (st_nxt != st_q);
    float_req  = (st_nxt == ST_GRANT) || (st_nxt == ST_REL);
    back_n_nxt = ~float_req;
    stall_nxt  = (st_nxt != ST_IDLE);
    resume_nxt = (st_q == ST_REL) && t_tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= ST_IDLE;
    else if (st_en) st_q <= st_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      back_n <= 1'b1;
      stall  <= 1'b0;
      resume <= 1'b0;
    end else begin
      back_n <= back_n_nxt;
      stall  <= stall_nxt;
      resume <= resume_nxt;
    end
  end

  // R2
  pend_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PEND && !t_tick) |=> (back_n && st_q == ST_PEND));
  // R2
  pend_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PEND && t_tick) |=> !back_n);
  // R8
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !take_req) |=> (back_n && !stall));
  // R5
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_REL && t_tick) |=> (back_n && resume));
  // R5
  resume_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume);
  // R6
  stall_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !back_n |-> stall);
endmodule

// File: rtl/bgc_float.sv
module bgc_float #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int N_STROBE = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                float_req,
  output logic [ADDR_W-1:0]   addr_oe,
  output logic [DATA_W-1:0]   data_oe,
  output logic [N_STROBE-1:0] strb_oe
);
  localparam int N_ALL = ADDR_W + DATA_W + N_STROBE;

  logic [N_ALL-1:0] oe_q;

  for (genvar i = 0; i < N_ALL; i++) begin : g_oe
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oe_q[i] <= 1'b1;
      else        oe_q[i] <= ~float_req;
    end
  end

  assign addr_oe = oe_q[ADDR_W-1:0];
  assign data_oe = oe_q[ADDR_W +: DATA_W];
  assign strb_oe = oe_q[ADDR_W+DATA_W +: N_STROBE];

  // R3
  oe_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&oe_q) || (~|oe_q));
endmodule

// File: rtl/bus_grant_ctrl.sv
module bus_grant_ctrl #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int N_STROBE = 5,
  parameter int RST_STG  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                t_tick,
  input  logic                last_t,
  input  logic                breq_n,
  output logic                back_n,
  output logic [ADDR_W-1:0]   addr_oe,
  output logic [DATA_W-1:0]   data_oe,
  output logic [N_STROBE-1:0] strb_oe,
  output logic                stall,
  output logic                resume
);
  logic rst_sync_n;
  logic take_req, seen_free, float_req;

  bgc_rst_sync #(.STAGES(RST_STG)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  bgc_sample u_sample (
    .t_tick(t_tick), .last_t(last_t), .breq_n(breq_n),
    .take_req(take_req), .seen_free(seen_free)
  );

  bgc_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .t_tick(t_tick),
    .take_req(take_req), .seen_free(seen_free),
    .float_req(float_req), .back_n(back_n), .stall(stall), .resume(resume)
  );

  bgc_float #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_STROBE(N_STROBE)) u_float (
    .clk(clk), .rst_n(rst_sync_n), .float_req(float_req),
    .addr_oe(addr_oe), .data_oe(data_oe), .strb_oe(strb_oe)
  );

  // R3
  drive_on_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    back_n |-> ((&addr_oe) && (&data_oe) && (&strb_oe)));
  // R3
  drive_off_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !back_n |-> (!(|addr_oe) && !(|data_oe) && !(|strb_oe)));
  // R1
  no_grant_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!t_tick && back_n) |=> back_n);
endmodule

// File: tb/bus_grant_ctrl_bench.sv
module bus_grant_ctrl_bench;
  localparam int NT = 4;
  localparam int AW = 16, DW = 8, NS = 5;
  localparam int NALL = AW + DW + NS;

  logic clk = 1'b0;
  logic rst_n, t_tick, last_t, breq_n;
  logic back_n, stall, resume;
  logic [AW-1:0] addr_oe;
  logic [DW-1:0] data_oe;
  logic [NS-1:0] strb_oe;

  int checks = 0, errors = 0;
  int ph, tcnt, mcyc, held_mcyc;
  logic e_back_n, e_stall, e_resume;

  always #2.5 clk = ~clk;

  bus_grant_ctrl u_bus_grant_ctrl (
    .clk(clk), .rst_n(rst_n), .t_tick(t_tick), .last_t(last_t), .breq_n(breq_n),
    .back_n(back_n), .addr_oe(addr_oe), .data_oe(data_oe), .strb_oe(strb_oe),
    .stall(stall), .resume(resume)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int next_ph(int p, logic t, logic l, logic r);
    case (p)
      0: return (t && l && !r) ? 1 : 0;
      1: return t ? 2 : 1;
      2: return (t && r) ? 3 : 2;
      default: return t ? 0 : 3;
    endcase
  endfunction

  task automatic check_all();
    chk("R2/R4/R5 back_n", 32'(back_n), 32'(e_back_n));
    chk("R3 enables", 32'({addr_oe, data_oe, strb_oe}), 32'({NALL{e_back_n}}));
    chk("R6 stall", 32'(stall), 32'(e_stall));
    chk("R5 resume", 32'(resume), 32'(e_resume));
    if (e_stall) chk("R7 held machine cycle", 32'(mcyc), 32'(held_mcyc));
  endtask

  task automatic step(input logic t, input logic r);
    logic l;
    l = (tcnt == NT - 1);
    t_tick = t; last_t = l; breq_n = r;
    @(posedge clk);
    if (t && !e_stall) begin
      if (tcnt == NT - 1) begin tcnt = 0; mcyc++; end
      else tcnt++;
    end
    e_resume = (ph == 3) && t;
    ph = next_ph(ph, t, l, r);
    e_back_n = !(ph == 2 || ph == 3);
    if (!e_stall && ph != 0) held_mcyc = mcyc;
    e_stall = (ph != 0);
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #(5ns * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic rq;
    void'($urandom(32'd20240607));
    rst_n = 1'b0; t_tick = 1'b0; last_t = 1'b0; breq_n = 1'b1;
    ph = 0; tcnt = 0; mcyc = 0; held_mcyc = 0;
    e_back_n = 1'b1; e_stall = 1'b0; e_resume = 1'b0;
    repeat (3) @(negedge clk);
    // R9: outputs while reset is held
    check_all();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9: outputs after the reset release
    check_all();

    // R8: request held low, tick only away from the last T state
    for (int i = 0; i < 12; i++) step(tcnt != NT - 1, 1'b0);
    chk("R8 ignored back_n", 32'(back_n), 32'd1);
    chk("R8 ignored stall", 32'(stall), 32'd0);
    // R1/R8: last T state reached but no tick
    while (tcnt != NT - 1) step(1'b1, 1'b1);
    step(1'b0, 1'b0);
    chk("R1 no tick back_n", 32'(back_n), 32'd1);
    // R1/R2: take the request, then stall before the acknowledge
    step(1'b1, 1'b0);
    chk("R2 pending back_n", 32'(back_n), 32'd1);
    chk("R6 pending stall", 32'(stall), 32'd1);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    chk("R2 granted back_n", 32'(back_n), 32'd0);
    // R4: hold, then release
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    chk("R5 release pending back_n", 32'(back_n), 32'd0);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    chk("R5 released back_n", 32'(back_n), 32'd1);
    chk("R5 resume pulse", 32'(resume), 32'd1);
    step(1'b1, 1'b1);
    chk("R5 resume single", 32'(resume), 32'd0);

    // random traffic
    rq = 1'b1;
    for (int i = 0; i < 6000; i++) begin
      if (($urandom % 8) == 0) rq = ~rq;
      step(($urandom % 4) != 0, rq);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule